// File: doc/BRIEF.md
# Single-Bus Register Add Sequencer

This block is a small processing datapath with a bank of general-purpose registers, one shared internal transfer bus, and an adder that keeps its two operands in private buffer registers. Because the bus can carry only one value per clock, a register-to-register add `Rd = Rs1 + Rs2` is broken into three steps, one per control state. First the bus carries the first source into the first operand buffer. Next it carries the second source into the second operand buffer. Last it carries the adder output back into the destination register.

A caller places the destination and the two source indices on the inputs and pulses `start` while the block is idle. The block raises `busy` for the three execute states. It then pulses `done` for one cycle, and in that same cycle the new destination value shows on the observation output. All register contents are always visible on `regs_obs`, so a caller can follow the state of the bank. After reset, register k holds the value k+1, which gives the adds non-zero data to work on.

Top module: `sbus_add_seq`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and register k holds k+1 (with the defaults: R0=1, R1=2, R2=3, R3=4).
- R2: A `start` sampled high while `busy` is 0 makes `busy` read 1 in each of the next three cycles, and 0 in the cycle after that.
- R3: `done` is high for exactly one cycle, the cycle in which `busy` has just fallen. In that cycle the destination already shows its new value.
- R4: The destination receives (value of source 1 + value of source 2) mod 2^DATA_W. Every other register keeps its value, and no register changes while `busy` is 1.
- R5: The destination may be the same as either source or both. The sum then uses the values the sources held before the instruction.
- R6: A `start` sampled while `busy` is 1 has no effect on the register contents or on the timing of the instruction that is running.
- R7: The shared bus makes at most one transfer per cycle, in this fixed order: source 1 into the first buffer, then source 2 into the second buffer, then the sum into the destination.
- R8: The indices are captured in the `start` cycle. Changing them while `busy` is 1 does not affect the instruction that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an add; accepted only while idle |
| dst_idx | input | IDX_W | Destination register index |
| src_a_idx | input | IDX_W | First source register index |
| src_b_idx | input | IDX_W | Second source register index |
| busy | output | 1 | High during the three execute states |
| done | output | 1 | One-cycle pulse after the write-back |
| regs_obs | output | NREG*DATA_W | All registers; register k is at bits [k*DATA_W +: DATA_W] |

## Verification
The hardest case to reach is an instruction whose destination is also a source, run while the inputs keep changing. In that case only the serial capture into the buffers keeps the old operand values in use. The bench runs through every combination of destination and source indices, including all the aliased ones, and follows with a long random sequence. During every execute cycle it drives fresh random indices and stray `start` pulses. The register values keep growing from the reset seed and wrap, so the sums also cross the 8-bit boundary.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LDA  = 2'd1,
    ST_LDB  = 2'd2,
    ST_WB   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] dst_in,
  input  logic [IDX_W-1:0] sa_in,
  input  logic [IDX_W-1:0] sb_in,
  output logic             ld_b1,
  output logic             ld_b2,
  output logic             wr_reg,
  output logic [IDX_W-1:0] rd_sel,
  output logic [IDX_W-1:0] wr_sel,
  output logic             busy,
  output logic             done
);
  import sbus_pkg::*;

  seq_state_t state, nxt;
  logic [IDX_W-1:0] dst_q, sa_q, sb_q;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_LDA;
      ST_LDA:  nxt = ST_LDB;
      ST_LDB:  nxt = ST_WB;
      ST_WB:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
      dst_q <= '0;
      sa_q  <= '0;
      sb_q  <= '0;
    end else begin
      state <= nxt;
      busy  <= (nxt != ST_IDLE);
      done  <= (state == ST_WB);
      if (state == ST_IDLE && start) begin
        dst_q <= dst_in;
        sa_q  <= sa_in;
        sb_q  <= sb_in;
      end
    end
  end

  assign ld_b1  = (state == ST_LDA);
  assign ld_b2  = (state == ST_LDB);
  assign wr_reg = (state == ST_WB);
  assign rd_sel = ld_b1 ? sa_q : sb_q;
  assign wr_sel = dst_q;
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       wsel,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [IDX_W-1:0]       rsel,
  output logic [DATA_W-1:0]      rdata,
  output logic [NREG*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] gpr [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        gpr[k] <= DATA_W'(k + 1);
      else if (we && wsel == IDX_W'(k))
        gpr[k] <= wdata;
    end
    assign flat[k*DATA_W +: DATA_W] = gpr[k];
  end

  assign rdata = gpr[rsel];
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_b1,
  input  logic              ld_b2,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] sum
);
  logic [DATA_W-1:0] buf1, buf2;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf1 <= '0;
      buf2 <= '0;
    end else begin
      if (ld_b1) buf1 <= bus_in;
      if (ld_b2) buf2 <= bus_in;
    end
  end

  assign sum = buf1 + buf2;
endmodule

// File: rtl/sbus_add_seq.sv
module sbus_add_seq #(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [IDX_W-1:0]       dst_idx,
  input  logic [IDX_W-1:0]       src_a_idx,
  input  logic [IDX_W-1:0]       src_b_idx,
  output logic                   busy,
  output logic                   done,
  output logic [NREG*DATA_W-1:0] regs_obs
);
  logic              ld_b1, ld_b2, wr_reg;
  logic [IDX_W-1:0]  rd_sel, wr_sel;
  logic [DATA_W-1:0] rf_rdata, alu_sum, bus_data;

  sbus_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .dst_in(dst_idx), .sa_in(src_a_idx), .sb_in(src_b_idx),
    .ld_b1(ld_b1), .ld_b2(ld_b2), .wr_reg(wr_reg),
    .rd_sel(rd_sel), .wr_sel(wr_sel), .busy(busy), .done(done)
  );

  // single shared bus: the ALU result drives it during write-back, a register otherwise
  assign bus_data = wr_reg ? alu_sum : rf_rdata;

  sbus_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(wr_reg), .wsel(wr_sel), .wdata(bus_data),
    .rsel(rd_sel), .rdata(rf_rdata), .flat(regs_obs)
  );

  sbus_alu #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst(rst), .ld_b1(ld_b1), .ld_b2(ld_b2),
    .bus_in(bus_data), .sum(alu_sum)
  );
endmodule

// File: rtl/sbus_add_seq_chk.sv
module sbus_add_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic ld_b1,
  input logic ld_b2,
  input logic wr_reg
);
  a_r7_one_transfer: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_b1, ld_b2, wr_reg}));
  a_r7_order_ab: assert property (@(posedge clk) disable iff (rst)
    ld_b1 |=> ld_b2);
  a_r7_order_bw: assert property (@(posedge clk) disable iff (rst)
    ld_b2 |=> wr_reg);
  a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && ld_b1));
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_reg) |=> busy);
  a_r3_done_after_wb: assert property (@(posedge clk) disable iff (rst)
    wr_reg |=> (done && !busy));
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> !ld_b1);
endmodule

bind sbus_add_seq sbus_add_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ld_b1(ld_b1), .ld_b2(ld_b2), .wr_reg(wr_reg)
);

// File: tb/sbus_add_seq_tb.sv
module sbus_add_seq_tb;
  localparam int DATA_W = 8;
  localparam int NREG   = 4;
  localparam int IDX_W  = $clog2(NREG);

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [IDX_W-1:0] dst_idx, src_a_idx, src_b_idx;
  logic busy, done;
  logic [NREG*DATA_W-1:0] regs_obs;

  int total = 0;
  int bad   = 0;
  logic [DATA_W-1:0] model [NREG];

  always #2 clk = ~clk;

  sbus_add_seq #(.DATA_W(DATA_W), .NREG(NREG)) u_dut (
    .clk(clk), .rst(rst), .start(start), .dst_idx(dst_idx),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .busy(busy), .done(done), .regs_obs(regs_obs)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < NREG; k++) begin
      total++;
      if (regs_obs[k*DATA_W +: DATA_W] !== model[k]) begin
        bad++;
        $display("FAIL %s: reg%0d actual=%0d expected=%0d at %0t", req, k,
                 regs_obs[k*DATA_W +: DATA_W], model[k], $time);
      end
    end
  endtask

  // Called at a negedge while idle; returns at the negedge where done is expected.
  task automatic run_add(input int d, input int a, input int b, input bit noisy);
    logic [DATA_W-1:0] expv;
    expv = model[a] + model[b];
    start     = 1'b1;
    dst_idx   = IDX_W'(d);
    src_a_idx = IDX_W'(a);
    src_b_idx = IDX_W'(b);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      // R8, R6: scramble the indices and raise stray starts while busy
      start     = noisy ? 1'($urandom_range(0, 1)) : 1'b0;
      dst_idx   = IDX_W'($urandom_range(0, NREG-1));
      src_a_idx = IDX_W'($urandom_range(0, NREG-1));
      src_b_idx = IDX_W'($urandom_range(0, NREG-1));
      check_bit("R2 busy in execute", busy, 1'b1);
      check_bit("R3 no early done", done, 1'b0);
      check_regs("R4 no change while busy");
    end
    start = 1'b0;
    @(negedge clk);
    model[d] = expv;
    check_bit("R2 busy falls", busy, 1'b0);
    check_bit("R3 done pulse", done, 1'b1);
    check_regs("R4 R5 R8 write-back");
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    dst_idx = '0; src_a_idx = '0; src_b_idx = '0;
    for (int k = 0; k < NREG; k++) model[k] = DATA_W'(k + 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_bit("R1 busy reset", busy, 1'b0);
    check_bit("R1 done reset", done, 1'b0);
    check_regs("R1 reset values");

    // R5 explicit full alias: R0 = R0 + R0
    run_add(0, 0, 0, 1'b0);
    // R3 done must drop in the next cycle when idle
    @(negedge clk);
    check_bit("R3 done one cycle", done, 1'b0);
    check_regs("R6 idle hold");

    // R4 R5 R7 exhaustive sweep of index triples, quiet then noisy
    for (int d = 0; d < NREG; d++)
      for (int a = 0; a < NREG; a++)
        for (int b = 0; b < NREG; b++)
          run_add(d, a, b, 1'b0);
    for (int d = 0; d < NREG; d++)
      for (int a = 0; a < NREG; a++)
        for (int b = 0; b < NREG; b++)
          run_add(d, a, b, 1'b1);

    // R4 wrap and R6 R8 under random back-to-back traffic
    for (int n = 0; n < 400; n++)
      run_add($urandom_range(0, NREG-1), $urandom_range(0, NREG-1),
              $urandom_range(0, NREG-1), 1'b1);

    @(negedge clk);
    check_bit("R3 final done low", done, 1'b0);
    check_bit("R2 final idle", busy, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule